// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single requests from an internal master into read or write cycles on an asynchronous-style external memory bus. It drives an active-low chip enable, output enable and write strobe, a registered address and a write data bus with its own output enable. Each cycle waits for a programmable number of clocks before its transfer point. An optional recovery gap of programmable length follows each cycle.

One shared acknowledge/ready pin is handled through separate value, enable and sampled-input signals. When the pin is configured as an input, it lets the external device decide when a cycle ends. Two polarities are available: an active-low acknowledge, or an active-high ready. When the pin is configured as an output, the block sends a single-clock low pulse on it to mark the moment data is sampled or written.

The master uses a valid/ready handshake carrying a write flag, an address and write data. Each access returns exactly one response pulse with the read data. Mode, pin direction, wait count and recovery length are sampled when a request is accepted.

Top module: `ext_bus_seq`

## Requirements
- R1: `req_ready` is high only while no access is in progress, requests offered at other times are ignored, and each accepted access produces exactly one `rsp_valid` pulse, in the first cycle after `bus_ce_n` returns high.
- R2: While `bus_ce_n` is low, `bus_addr` holds the accepted address. A read keeps `bus_oe_n` low and `bus_we_n` high for exactly the cycles of `bus_ce_n` low; a write does the reverse. Both strobes are high whenever `bus_ce_n` is high.
- R3: For mode code 00 (normal) and code 11 (treated as normal) with W programmed waits, `bus_ce_n` stays low for W+1 cycles on a read and W+2 cycles on a write.
- R4: With the pin dynamic and the mode normal, `ack_o` is driven low with `ack_oe` high for exactly one clock, the (W+1)th cycle of `bus_ce_n` low. No pulse appears in any other setting.
- R5: A read captures `bus_data_i` on the rising edge that ends its transfer cycle, the (W+1)th low cycle in normal mode, and returns it on `rsp_rdata`.
- R6: On a normal write, `bus_we_n` stays low for one cycle after the acknowledge pulse, then rises together with `bus_ce_n`. `bus_data_oe` stays high with the write data for one further cycle.
- R7: With `cfg_pin_dynamic` low (static), `ack_oe` is low at all times.
- R8: With the pin dynamic, `ack_oe` is high with `ack_o` high while idle. On a mode 01/10 access, `ack_oe` goes low in the first cycle `bus_ce_n` is low, stays low through the first cycle `bus_ce_n` is high again, and returns high in the cycle after that.
- R9: In mode 01 the access ends at the first rising edge after the W waits at which `ack_i` is low. In mode 10 it ends at the first such edge at which `ack_i` is high. The pin is ignored during the waits. Read data is captured at the ending edge, and a write releases `bus_ce_n` and `bus_we_n` there.
- R10: With recovery H, `req_ready` returns high H+1 cycles after `bus_ce_n` rises.
- R11: Synchronous reset leaves all strobes high, `bus_data_oe` low, `req_ready` high, `rsp_valid` low, and `ack_oe` equal to `cfg_pin_dynamic`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00 normal, 01 external acknowledge, 10 ready, 11 normal |
| cfg_pin_dynamic | input | 1 | 1: pin direction follows the mode; 0: pin is always an input |
| cfg_wait | input | WAIT_W | Wait clocks before the transfer point |
| cfg_hold | input | HOLD_W | Recovery clocks after an access |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | External address |
| bus_data_o | output | DATA_W | Write data to the pad |
| bus_data_oe | output | 1 | Data pad drive enable |
| bus_data_i | input | DATA_W | Data from the pad |
| ack_o | output | 1 | Acknowledge pin value when driven |
| ack_oe | output | 1 | Acknowledge pin drive enable |
| ack_i | input | 1 | Acknowledge/ready pin as sampled |

## Verification
The bench uses the default parameters: a 20-bit address, 32-bit data, a 4-bit wait field, a 2-bit recovery field and an active-high ready. With these values every wait count from 0 to 15 and every recovery gap from 0 to 3 can be exercised, in each of the four modes and both pin settings. The external device model presents valid read data only in the expected capture cycle. It can also assert the pin during waits and delay termination, so the release and re-drive points, the end of the write strobe and the capture edge are checked against lengths computed per access.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_STROBE,
      ST_WREL,
      ST_TAIL,
      ST_HOLD
   } ebs_state_e;

   localparam logic [1:0] MD_NORMAL = 2'b00;
   localparam logic [1:0] MD_EXTACK = 2'b01;
   localparam logic [1:0] MD_READY  = 2'b10;

   function automatic logic mode_is_input(input logic [1:0] m);
      return (m == MD_EXTACK) || (m == MD_READY);
   endfunction

endpackage

// File: rtl/ebs_down_ctr.sv
module ebs_down_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ebs_ack_pin.sv
module ebs_ack_pin (
   input  logic clk,
   input  logic rst,
   input  logic cfg_dyn,
   input  logic busy,
   input  logic lat_dyn,
   input  logic rel_set,
   input  logic rel_clr,
   input  logic pulse,
   output logic ack_oe,
   output logic ack_o
);

   logic rel_q;

   always_ff @(posedge clk) begin
      if (rst)          rel_q <= 1'b0;
      else if (rel_set) rel_q <= 1'b1;
      else if (rel_clr) rel_q <= 1'b0;
   end

   assign ack_oe = (busy ? lat_dyn : cfg_dyn) & ~rel_q;
   assign ack_o  = ~pulse;

   AST_ACK_SINGLE_CLK: assert property (@(posedge clk) disable iff (rst)
      !ack_o |=> ack_o); // R4
   AST_ACK_PULSE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      !ack_o |-> ack_oe); // R4

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 32,
   parameter int WAIT_W         = 4,
   parameter int HOLD_W         = 2,
   parameter bit READY_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_pin_dynamic,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic [HOLD_W-1:0] cfg_hold,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_ce_n,
   output logic              bus_oe_n,
   output logic              bus_we_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic              ack_o,
   output logic              ack_oe,
   input  logic              ack_i
);

   localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ext_bus_seq: address and data widths must be positive");
   end
   if (WAIT_W < 1 || HOLD_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("ext_bus_seq: wait/hold fields must be 1 to 16 bits");
   end

   ebs_state_e        state_q;
   logic              lat_write, lat_dyn;
   logic [1:0]        lat_mode;
   logic [HOLD_W-1:0] lat_hold;
   logic              accept, lat_input, rdy_seen, term;
   logic              ctr_load, ctr_dec, ctr_zero;
   logic [CNT_W-1:0]  ctr_val;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready & req_valid;
   assign lat_input = mode_is_input(lat_mode);

   if (READY_ACT_HIGH) begin : g_rdy_high
      assign rdy_seen = ack_i;
   end else begin : g_rdy_low
      assign rdy_seen = ~ack_i;
   end

   always_comb begin
      if (lat_mode == MD_EXTACK)     term = ~ack_i;
      else if (lat_mode == MD_READY) term = rdy_seen;
      else                           term = 1'b1;
   end

   // One counter serves the wait phase and the recovery phase
   always_comb begin
      ctr_load = 1'b0;
      ctr_val  = '0;
      if (accept && cfg_wait != '0) begin
         ctr_load = 1'b1;
         ctr_val  = CNT_W'(cfg_wait) - CNT_W'(1);
      end else if (state_q == ST_TAIL && lat_hold != '0) begin
         ctr_load = 1'b1;
         ctr_val  = CNT_W'(lat_hold) - CNT_W'(1);
      end
   end
   assign ctr_dec = (state_q == ST_WAIT || state_q == ST_HOLD) && !ctr_zero;

   ebs_down_ctr #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ctr_load),
      .load_val (ctr_val),
      .dec      (ctr_dec),
      .zero     (ctr_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         bus_ce_n    <= 1'b1;
         bus_oe_n    <= 1'b1;
         bus_we_n    <= 1'b1;
         bus_data_oe <= 1'b0;
         bus_addr    <= '0;
         bus_data_o  <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         lat_write   <= 1'b0;
         lat_dyn     <= 1'b0;
         lat_mode    <= MD_NORMAL;
         lat_hold    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  lat_write   <= req_write;
                  lat_dyn     <= cfg_pin_dynamic;
                  lat_mode    <= cfg_mode;
                  lat_hold    <= cfg_hold;
                  bus_addr    <= req_addr;
                  bus_data_o  <= req_wdata;
                  bus_ce_n    <= 1'b0;
                  bus_oe_n    <= req_write;
                  bus_we_n    <= ~req_write;
                  bus_data_oe <= req_write;
                  state_q     <= (cfg_wait == '0) ? ST_STROBE : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ctr_zero) state_q <= ST_STROBE;
            end
            ST_STROBE: begin
               if (term) begin
                  if (!lat_write) begin
                     rsp_rdata <= bus_data_i;
                     rsp_valid <= 1'b1;
                     bus_ce_n  <= 1'b1;
                     bus_oe_n  <= 1'b1;
                     state_q   <= ST_TAIL;
                  end else if (lat_input) begin
                     rsp_valid <= 1'b1;
                     bus_ce_n  <= 1'b1;
                     bus_we_n  <= 1'b1;
                     state_q   <= ST_TAIL;
                  end else begin
                     state_q   <= ST_WREL;
                  end
               end
            end
            ST_WREL: begin
               rsp_valid <= 1'b1;
               bus_ce_n  <= 1'b1;
               bus_we_n  <= 1'b1;
               state_q   <= ST_TAIL;
            end
            ST_TAIL: begin
               bus_data_oe <= 1'b0;
               state_q     <= (lat_hold == '0) ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
               if (ctr_zero) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   ebs_ack_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .cfg_dyn (cfg_pin_dynamic),
      .busy    (!req_ready),
      .lat_dyn (lat_dyn),
      .rel_set (accept && mode_is_input(cfg_mode)),
      .rel_clr (state_q == ST_TAIL),
      .pulse   (state_q == ST_STROBE && !lat_input && lat_dyn),
      .ack_oe  (ack_oe),
      .ack_o   (ack_o)
   );

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_addr)); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(!bus_oe_n && !bus_we_n)); // R2
   AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
      bus_ce_n |-> (bus_oe_n && bus_we_n)); // R2
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (bus_ce_n && !bus_data_oe)); // R1
   AST_RSP_ONCE: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid); // R1
   AST_RSP_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ($rose(bus_ce_n))); // R1
   AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
      (!bus_ce_n && lat_input) |-> !ack_oe); // R8
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_we_n) |-> bus_data_oe); // R6
   AST_STATIC_INPUT: assert property (@(posedge clk) disable iff (rst)
      (!bus_ce_n && !lat_dyn) |-> !ack_oe); // R7

endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;

   localparam int AW = 20;
   localparam int DW = 32;
   localparam logic [DW-1:0] GOOD = 32'hC0DE_5A17;
   localparam logic [DW-1:0] BAD  = 32'hDEAD_0BAD;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    cfg_mode;
   logic          cfg_pin_dynamic;
   logic [3:0]    cfg_wait;
   logic [1:0]    cfg_hold;
   logic          req_valid, req_ready, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          bus_ce_n, bus_oe_n, bus_we_n, bus_data_oe;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data_o, bus_data_i;
   logic          ack_o, ack_oe, ack_i;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   ext_bus_seq dut (
      .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_pin_dynamic(cfg_pin_dynamic),
      .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
      .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
      .bus_data_i(bus_data_i), .ack_o(ack_o), .ack_oe(ack_oe), .ack_i(ack_i)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit is_in(input int md);
      return md == 1 || md == 2;
   endfunction

   function automatic int exp_ce(input bit wr, input int md, input int w, input int d);
      if (is_in(md)) return w + 1 + d;
      return w + 2 + (wr ? 1 : 0) - 1;
   endfunction

   function automatic bit pin_level(input int md, input bit active);
      if (md == 1) return !active;
      return active;
   endfunction

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int md, input bit dyn, input int w, input int h,
                         input int dly, input bit noise);
      int ce_cnt = 0, ack_cnt = 0, ack_pos = -1, rel_cnt = 0, doe_cnt = 0;
      int rsp_cnt = 0, rsp_pos = -1, ready_pos = -1;
      int addr_err = 0, str_err = 0, dat_err = 0;
      int ece, eend;
      logic [DW-1:0] got = '0;
      bit act;
      ece  = exp_ce(wr, md, w, is_in(md) ? dly : 0);
      eend = w + 1 + (is_in(md) ? dly : 0);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cfg_mode = md[1:0]; cfg_pin_dynamic = dyn; cfg_wait = w[3:0]; cfg_hold = h[1:0];
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      ack_i = pin_level(md, 1'b0); bus_data_i = BAD;
      @(posedge clk);
      for (int k = 1; k < 300; k++) begin
         @(negedge clk);
         if (!bus_ce_n) begin
            ce_cnt++;
            if (bus_addr != a) addr_err++;
            if (bus_oe_n != wr || bus_we_n != !wr) str_err++;
         end else if (!bus_oe_n || !bus_we_n) str_err++;
         if (!ack_o && ack_oe) begin ack_cnt++; ack_pos = ce_cnt; end
         if (!ack_oe) rel_cnt++;
         if (bus_data_oe) begin doe_cnt++; if (bus_data_o != d) dat_err++; end
         if (rsp_valid) begin rsp_cnt++; rsp_pos = k; got = rsp_rdata; end
         if (req_ready) begin ready_pos = k; req_valid = 1'b0; break; end
         // request held with other contents to confirm it is ignored (R1)
         req_addr = ~a; req_wdata = ~d; req_write = !wr;
         act = !bus_ce_n && ((ce_cnt >= eend) || (noise && ce_cnt <= w));
         ack_i = pin_level(md, act);
         bus_data_i = (!bus_ce_n && ce_cnt == eend) ? GOOD : BAD;
      end
      ack_i = pin_level(md, 1'b0);
      chk(ce_cnt == ece, is_in(md) ? "R9 CE low length" : "R3 CE low length", ce_cnt, ece);
      chk(str_err == 0 && addr_err == 0, "R2 strobes/address", str_err + addr_err, 0);
      chk(ack_cnt == ((!is_in(md) && dyn) ? 1 : 0), "R4 ack pulse count", ack_cnt,
          (!is_in(md) && dyn) ? 1 : 0);
      if (!is_in(md) && dyn) chk(ack_pos == w + 1, "R4 ack pulse position", ack_pos, w + 1);
      chk(rsp_cnt == 1 && rsp_pos == ece + 1, "R1 single response", rsp_pos, ece + 1);
      if (!wr) chk(got == GOOD, is_in(md) ? "R9 read capture" : "R5 read capture", got, GOOD);
      else chk(doe_cnt == ece + 1 && dat_err == 0, "R6 write data hold", doe_cnt, ece + 1);
      if (!dyn) chk(rel_cnt == ready_pos, "R7 static input", rel_cnt, ready_pos);
      else if (is_in(md)) chk(rel_cnt == ece + 1, "R8 release window", rel_cnt, ece + 1);
      else chk(rel_cnt == 0, "R8 driven in normal", rel_cnt, 0);
      chk(ready_pos == ece + 2 + h, "R10 recovery", ready_pos, ece + 2 + h);
   endtask

   initial begin
      void'($urandom(32'h5EED_2024));
      rst = 1'b1; cfg_mode = 2'b00; cfg_pin_dynamic = 1'b0; cfg_wait = '0; cfg_hold = '0;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      bus_data_i = BAD; ack_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      chk(req_ready && bus_ce_n && bus_oe_n && bus_we_n && !bus_data_oe && !rsp_valid,
          "R11 reset strobes", {req_ready, bus_ce_n, bus_oe_n, bus_we_n, bus_data_oe}, 5'b11110);
      chk(ack_oe == 1'b0, "R11 reset pin static", ack_oe, 0);
      cfg_pin_dynamic = 1'b1;
      @(negedge clk);
      chk(ack_oe && ack_o, "R8 idle drive high", {ack_oe, ack_o}, 2'b11);

      // directed corners
      access(0, 20'h00010, 32'h1, 0, 1, 0, 0, 0, 0);
      access(1, 20'h00020, 32'hA5A5_0001, 0, 1, 0, 0, 0, 0);
      access(0, 20'hFFFFF, 32'h2, 0, 1, 15, 3, 0, 0);
      access(1, 20'h12345, 32'h0BAD_CAFE, 0, 1, 15, 3, 0, 0);
      access(0, 20'h00030, 32'h3, 3, 1, 2, 0, 0, 0);
      access(1, 20'h00040, 32'h4, 0, 0, 2, 1, 0, 0);
      access(0, 20'h00050, 32'h5, 1, 1, 2, 0, 0, 1);
      access(1, 20'h00060, 32'h6, 1, 1, 0, 0, 4, 0);
      access(0, 20'h00070, 32'h7, 2, 1, 3, 2, 5, 1);
      access(1, 20'h00080, 32'h8, 2, 0, 1, 0, 0, 1);
      access(0, 20'h00090, 32'h9, 1, 0, 0, 0, 0, 0);

      for (int i = 0; i < 60; i++) begin
         access(1'($urandom_range(0, 1)), 20'($urandom), $urandom,
                int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
      end

      @(negedge clk);
      summary();
   end

endmodule